// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards a transmitter against runaway transmissions. It watches the internal transmit-enable signal and counts the timebase ticks during which that signal stays high. If a transmission lasts past the allowed limit, the block trips: it drops its gate output so the line drivers stop, and it raises a status flag.

Once tripped, the block stays tripped for as long as transmit-enable remains high, however long that is. It re-opens the gate only after transmit-enable has stayed low for an unbroken quiet interval. Any return of transmit-enable during that interval restarts the quiet count from zero.

Both intervals are parameters counted in ticks of an external timebase. A strobe at 1 µs gives about 26 ms and 750 ms with the defaults, and a simulation can use short values. There is no data stream and no handshake: all pins are plain control and status levels, and the tick is a single-cycle strobe sampled on the clock.

Top module: `jabber_watchdog`

## Requirements
- R1: While `rst_n` is low, and after its release until a trip, `jabber` is 0 and `tx_gate` is 1.
- R2: `tx_gate` is always the inverse of `jabber`.
- R3: With the block not tripped, `jabber` rises at the clock edge that samples the JAB_TICKS-th tick seen while `tx_en` has been continuously high. Fewer such ticks never trip it.
- R4: The transmit count restarts from zero whenever `tx_en` goes low, so bursts of JAB_TICKS-1 ticks separated by any low period never trip.
- R5: While tripped, `jabber` stays 1 for as long as `tx_en` is high, whatever the number of ticks.
- R6: While tripped, `jabber` falls at the clock edge that samples the UNJAB_TICKS-th tick seen while `tx_en` has been continuously low. Fewer such ticks keep it at 1.
- R7: Any cycle with `tx_en` high during the quiet interval restarts the quiet count from zero.
- R8: Clock cycles without `tick` advance neither count, so `jabber` changes only at an edge where `tick` is 1.
- R9: `jabber` rises only at an edge where `tx_en` is 1 and falls only at an edge where `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| tx_en | input | 1 | Internal transmit-enable |
| tx_gate | output | 1 | 1 when the transmit outputs may drive the line |
| jabber | output | 1 | 1 from a trip until re-enable |

## Verification
The bench uses transmissions that end one tick short of the limit and transmissions that reach it. This shows whether the trip lands on exactly the right tick. Bursts just under the limit, separated by short low gaps, show whether the count restarts or accumulates. Long stretches of clock with no tick show that only the timebase advances time. Quiet periods cut short by a single-cycle reassertion show whether the quiet count restarts or merely pauses. A long hold with transmit-enable high shows that a tripped block does not release on its own.

// File: rtl/jab_pkg.sv
package jab_pkg;
  typedef enum logic {
    JS_RUN     = 1'b0,
    JS_TRIPPED = 1'b1
  } jab_state_e;
endpackage

// File: rtl/jab_tick_counter.sv
// Counts qualified ticks; flags the last count before the limit.
module jab_tick_counter #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [W-1:0] count_q;

  assign last = (count_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= last ? '0 : count_q + 1'b1;
    end
  end
endmodule

// File: rtl/jab_state_ctl.sv
// Two-state trip control.
module jab_state_ctl
  import jab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_en,
  input  logic jab_last,
  input  logic unjab_last,
  output logic tripped
);
  jab_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      JS_RUN:     if (tx_en && tick && jab_last) state_d = JS_TRIPPED;
      JS_TRIPPED: if (!tx_en && tick && unjab_last) state_d = JS_RUN;
      default:    state_d = JS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= JS_RUN;
    else        state_q <= state_d;
  end

  assign tripped = (state_q == JS_TRIPPED);
endmodule

// File: rtl/jabber_watchdog.sv
module jabber_watchdog #(
  parameter int unsigned JAB_TICKS   = 26000,
  parameter int unsigned UNJAB_TICKS = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_en,
  output logic tx_gate,
  output logic jabber
);
  logic tripped;
  logic jab_last, unjab_last;
  logic jab_clr, jab_inc, unjab_clr, unjab_inc;

  // Transmit-length timer: runs only while not tripped and tx_en is high.
  assign jab_clr = !tx_en || tripped;
  assign jab_inc = tick && tx_en && !tripped;

  // Quiet timer: runs only while tripped and tx_en is low.
  assign unjab_clr = tx_en || !tripped;
  assign unjab_inc = tick && !tx_en && tripped;

  jab_tick_counter #(.LIMIT(JAB_TICKS)) u_jab_cnt (
    .clk(clk), .rst_n(rst_n), .clr(jab_clr), .inc(jab_inc), .last(jab_last)
  );

  jab_tick_counter #(.LIMIT(UNJAB_TICKS)) u_unjab_cnt (
    .clk(clk), .rst_n(rst_n), .clr(unjab_clr), .inc(unjab_inc), .last(unjab_last)
  );

  jab_state_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en),
    .jab_last(jab_last), .unjab_last(unjab_last), .tripped(tripped)
  );

  assign jabber  = tripped;
  assign tx_gate = !tripped;
endmodule

// File: rtl/jabber_watchdog_chk.sv
module jabber_watchdog_chk #(
  parameter int unsigned JAB_TICKS   = 26000,
  parameter int unsigned UNJAB_TICKS = 750000
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_en,
  input logic tx_gate,
  input logic jabber
);
  int unsigned hi_cnt, lo_cnt;

  // Independent tick counts observed at the ports.
  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en || jabber) hi_cnt <= 0;
    else if (tick) hi_cnt <= hi_cnt + 1;
    if (!rst_n || tx_en || !jabber) lo_cnt <= 0;
    else if (tick) lo_cnt <= lo_cnt + 1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !jabber);

  // R2
  gate_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_gate != jabber);

  // R3
  trip_on_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jabber && tx_en && tick && hi_cnt == JAB_TICKS - 1) |=> jabber);

  // R3
  no_early_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jabber && !(tx_en && tick && hi_cnt == JAB_TICKS - 1)) |=> !jabber);

  // R5
  hold_while_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jabber && tx_en) |=> jabber);

  // R6
  release_on_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jabber && !tx_en && tick && lo_cnt == UNJAB_TICKS - 1) |=> !jabber);

  // R7
  no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jabber && !(!tx_en && tick && lo_cnt == UNJAB_TICKS - 1)) |=> jabber);

  // R8
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(jabber));

  // R9
  rise_with_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!jabber && !tx_en) |=> !jabber);
endmodule

bind jabber_watchdog jabber_watchdog_chk #(
  .JAB_TICKS(JAB_TICKS), .UNJAB_TICKS(UNJAB_TICKS)
) u_chk (.*);

// File: tb/jabber_watchdog_bench.sv
module jabber_watchdog_bench;
  localparam int unsigned JAB   = 8;
  localparam int unsigned UNJAB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tx_en = 1'b0;
  logic tx_gate, jabber;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  jabber_watchdog #(.JAB_TICKS(JAB), .UNJAB_TICKS(UNJAB)) u_jabber_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en),
    .tx_gate(tx_gate), .jabber(jabber)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One clock: drive at the falling edge, outputs settle after the rising edge.
  task automatic cyc(input logic t, input logic e);
    @(negedge clk);
    tick = t;
    tx_en = e;
    @(posedge clk);
    #1;
  endtask

  // n ticks, each followed by two idle cycles, all with tx_en = e.
  task automatic ticks(input int n, input logic e);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, e);
      cyc(1'b0, e);
      cyc(1'b0, e);
    end
  endtask

  task automatic chk(input string req, input logic exp_jab);
    checks++;
    if (jabber !== exp_jab || tx_gate !== !exp_jab) begin
      errors++;
      $display("FAIL %s: jabber=%b tx_gate=%b expected jabber=%b tx_gate=%b",
               req, jabber, tx_gate, exp_jab, !exp_jab);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(1'b1, 1'b1);
    chk("R1 in reset", 1'b0);
    cyc(1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R1 after release", 1'b0);
  endtask

  task automatic t_short();
    ticks(JAB - 1, 1'b1);
    chk("R3 one tick short", 1'b0);
    cyc(1'b0, 1'b0);
  endtask

  task automatic t_restart();
    for (int b = 0; b < 3; b++) begin
      ticks(JAB - 1, 1'b1);
      cyc(1'b0, 1'b0);
    end
    chk("R4 bursts separated by gaps", 1'b0);
  endtask

  task automatic t_no_tick();
    ticks(JAB - 1, 1'b1);
    for (int i = 0; i < 200; i++) cyc(1'b0, 1'b1);
    chk("R8 no tick no trip", 1'b0);
    cyc(1'b1, 1'b1);
    chk("R3 limit tick after idle", 1'b1);
  endtask

  task automatic t_hold();
    ticks(5 * JAB, 1'b1);
    chk("R5 held while tx_en high", 1'b1);
    for (int i = 0; i < 100; i++) cyc(1'b0, 1'b1);
    chk("R5 still held", 1'b1);
  endtask

  task automatic t_unjab();
    ticks(UNJAB - 1, 1'b0);
    chk("R6 one quiet tick short", 1'b1);
    for (int i = 0; i < 100; i++) cyc(1'b0, 1'b0);
    chk("R8 quiet without tick", 1'b1);
    cyc(1'b1, 1'b0);
    chk("R6 release on limit", 1'b0);
  endtask

  task automatic t_reassert();
    ticks(JAB - 1, 1'b1);
    chk("R3 short before trip", 1'b0);
    ticks(1, 1'b1);
    chk("R3 trip on limit", 1'b1);
    ticks(UNJAB - 1, 1'b0);
    cyc(1'b0, 1'b1);
    chk("R7 reassert keeps trip", 1'b1);
    ticks(UNJAB - 1, 1'b0);
    chk("R7 count restarted", 1'b1);
    ticks(1, 1'b0);
    chk("R6 release after full quiet", 1'b0);
    ticks(1, 1'b1);
    chk("R9 fresh transmission not tripped", 1'b0);
    cyc(1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_short();
    t_restart();
    t_no_tick();
    t_hold();
    t_unjab();
    t_reassert();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule